// File: doc/BRIEF.md
# ITU-R 656 Stream Filter

The block sits on a parallel digital-video symbol stream of 8 or 10 bits per symbol and forwards only a chosen part of each field. It searches the stream for the four-symbol timing reference (one all-ones code, two all-zero codes, then a status word). From each status word whose protection bits are consistent it takes the field, vertical-blanking and horizontal flags. Until the field flag has been seen falling from 1 to 0, which marks the start of field 1, nothing leaves the block.

A two-bit selector picks one of four behaviours. It can forward active picture samples only, with every timing reference stripped. It can forward vertical-blanking samples only. It can forward the whole stream, timing references included. It can forward nothing. A programmable limit on the number of active lines closes the capture once that many active-line end codes have passed. Input symbols pass through a three-symbol window, so that a timing reference can be recognised as a whole and then removed. A forwarded symbol therefore leaves the block three accepted symbols after it entered.

Top module: `itu656_filter`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `out_valid`, `synced` and `capture_done` are 0.
- R2: A timing reference is four accepted symbols whose upper 8 bits are 0xFF, 0x00, 0x00 and then a status byte S. S is valid only when it equals {1, F, V, H, V^H, F^H, F^V, F^V^H}, where F = S[6], V = S[5] and H = S[4]. H = 1 marks end of active video and H = 0 marks start of active video. If S is not valid, the four symbols are plain data and the tracked flags do not change.
- R3: `synced` rises on the cycle after the clock edge that accepts a valid status with F = 0, when the previous valid status had F = 1. It then stays high until reset. No symbol accepted at or before that edge is ever forwarded.
- R4: A forwarded symbol appears on `out_data` with `out_valid` high for exactly one cycle. That cycle follows the edge that accepts the third symbol after it.
- R5: With `mode` = 0, the block forwards only symbols that belong to no valid timing reference and that arrive after a valid status with H = 0 and V = 0, up to the next valid timing reference.
- R6: With `mode` = 1, the block forwards only symbols that belong to no valid timing reference and that arrive while the most recent valid status had V = 1.
- R7: With `mode` = 2, every symbol accepted after the sync status is forwarded, timing references and blanking data included.
- R8: With `mode` = 3, nothing is forwarded.
- R9: After sync, each valid status with H = 1 and V = 0 counts one active line. When the count reaches a nonzero `active_lines`, `capture_done` goes high on the next cycle and stays high. No symbol accepted after that edge is forwarded. A limit of 0 sets no limit.
- R10: A cycle with `sym_valid` low neither advances the window nor produces output.
- R11: Detection uses only the upper 8 bits of each symbol. Forwarded symbols keep all SYM_W bits, the lower bits of a 10-bit symbol included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Symbol on `sym_in` is accepted this cycle |
| sym_in | input | SYM_W | Video symbol |
| mode | input | 2 | 0 active only, 1 vertical blanking only, 2 whole stream, 3 none; hold stable between resets |
| active_lines | input | LINE_W | Active lines to capture, 0 for no limit |
| out_valid | output | 1 | `out_data` holds a forwarded symbol |
| out_data | output | SYM_W | Forwarded symbol |
| synced | output | 1 | Start of field 1 has been found |
| capture_done | output | 1 | Active-line limit reached |

## Verification
The symbol accepted at one edge comes out one cycle after the edge that accepts the third symbol after it. `synced` and `capture_done` change one cycle after the edge that accepts the deciding status byte. Idle cycles stretch the window in clock cycles but not in symbols. The bench model advances on the same rising edge as the design, updating its window and flags. All comparisons are made on the falling edge, so each expected value is due exactly in the cycle where it is compared. Idle gaps are inserted into every stream, so the symbol-count latency is checked separately from the clock-count latency.

// File: rtl/itu656_pkg.sv
package itu656_pkg;

    // Timing reference: one high code, two low codes, one status byte.
    localparam int PRE_LEN = 4;
    localparam int WIN_LEN = PRE_LEN - 1;
    localparam logic [7:0] CODE_HI = 8'hFF;
    localparam logic [7:0] CODE_LO = 8'h00;

    typedef enum logic [1:0] {
        SEL_ACTIVE = 2'd0,
        SEL_VBLANK = 2'd1,
        SEL_ALL    = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trs_flags_t;

    // Region snapshot taken when a symbol enters the window.
    typedef struct packed {
        logic synced;
        logic v;
        logic h;
        logic done;
    } region_t;

    function automatic logic [7:0] build_status(trs_flags_t t);
        return {1'b1, t.f, t.v, t.h, t.v ^ t.h, t.f ^ t.h, t.f ^ t.v, t.f ^ t.v ^ t.h};
    endfunction

    function automatic trs_flags_t status_flags(logic [7:0] b);
        trs_flags_t t;
        t.f = b[6];
        t.v = b[5];
        t.h = b[4];
        return t;
    endfunction

    function automatic logic status_ok(logic [7:0] b);
        return b == build_status(status_flags(b));
    endfunction

    // Expected code per window slot; slot WIN_LEN-1 is the oldest.
    function automatic logic [7:0] preamble_code(int pos);
        return (pos == WIN_LEN - 1) ? CODE_HI : CODE_LO;
    endfunction

endpackage

// File: rtl/itu656_trs_detect.sv
module itu656_trs_detect
    import itu656_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic [WIN_LEN-1:0][SYM_W-1:0] win_sym,
    input  logic [WIN_LEN-1:0]            win_vld,
    input  logic [SYM_W-1:0]              cur_sym,
    output logic                          hit,
    output trs_flags_t                    flags
);

    localparam int HI_LSB = SYM_W - 8;

    logic [WIN_LEN-1:0] pos_match;
    logic [7:0]         cur_hi;

    genvar i;
    generate
        for (i = 0; i < WIN_LEN; i++) begin : g_pos
            assign pos_match[i] = win_vld[i] &&
                                  (win_sym[i][SYM_W-1:HI_LSB] == preamble_code(i));
        end
    endgenerate

    assign cur_hi = cur_sym[SYM_W-1:HI_LSB];
    assign hit    = (&pos_match) && status_ok(cur_hi);
    assign flags  = status_flags(cur_hi);

endmodule

// File: rtl/itu656_sym_window.sv
module itu656_sym_window
    import itu656_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic [SYM_W-1:0]              sym_in,
    input  region_t                       region_in,
    input  logic                          mark_ctrl,
    output logic [WIN_LEN-1:0][SYM_W-1:0] win_sym,
    output logic [WIN_LEN-1:0]            win_vld,
    output logic                          exit_vld,
    output logic [SYM_W-1:0]              exit_sym,
    output region_t                       exit_region,
    output logic                          exit_ctrl
);

    localparam int LAST = WIN_LEN - 1;

    logic    [WIN_LEN-1:0] ctrl_q;
    region_t [WIN_LEN-1:0] reg_q;

    genvar i;
    generate
        for (i = 0; i < WIN_LEN; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) begin
                        win_vld[i] <= 1'b0;
                        win_sym[i] <= '0;
                        ctrl_q[i]  <= 1'b0;
                        reg_q[i]   <= '0;
                    end else if (push) begin
                        win_vld[i] <= 1'b1;
                        win_sym[i] <= sym_in;
                        ctrl_q[i]  <= mark_ctrl;
                        reg_q[i]   <= region_in;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) begin
                        win_vld[i] <= 1'b0;
                        win_sym[i] <= '0;
                        ctrl_q[i]  <= 1'b0;
                        reg_q[i]   <= '0;
                    end else if (push) begin
                        win_vld[i] <= win_vld[i-1];
                        win_sym[i] <= win_sym[i-1];
                        ctrl_q[i]  <= ctrl_q[i-1] | mark_ctrl;
                        reg_q[i]   <= reg_q[i-1];
                    end
                end
            end
        end
    endgenerate

    // The oldest slot leaves on a push; a completed reference tags it too.
    assign exit_vld    = win_vld[LAST];
    assign exit_sym    = win_sym[LAST];
    assign exit_region = reg_q[LAST];
    assign exit_ctrl   = ctrl_q[LAST] | mark_ctrl;

endmodule

// File: rtl/itu656_timing_track.sv
module itu656_timing_track
    import itu656_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              hit,
    input  trs_flags_t        flags,
    input  logic [LINE_W-1:0] line_limit,
    output region_t           region
);

    logic              f_q;
    logic              v_q;
    logic              h_q;
    logic              seen_q;
    logic              sync_q;
    logic              done_q;
    logic [LINE_W-1:0] eav_cnt_q;

    logic              take;
    logic              sync_edge;
    logic              line_end;
    logic [LINE_W-1:0] cnt_next;

    assign take      = push && hit;
    assign sync_edge = take && !sync_q && seen_q && f_q && !flags.f;
    assign line_end  = take && sync_q && !done_q && flags.h && !flags.v;
    assign cnt_next  = eav_cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q       <= 1'b0;
            v_q       <= 1'b1;
            h_q       <= 1'b1;
            seen_q    <= 1'b0;
            sync_q    <= 1'b0;
            done_q    <= 1'b0;
            eav_cnt_q <= '0;
        end else begin
            if (take) begin
                f_q    <= flags.f;
                v_q    <= flags.v;
                h_q    <= flags.h;
                seen_q <= 1'b1;
            end
            if (sync_edge) begin
                sync_q <= 1'b1;
            end
            if (line_end) begin
                eav_cnt_q <= cnt_next;
                if ((line_limit != '0) && (cnt_next == line_limit)) begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        region.synced = sync_q;
        region.v      = v_q;
        region.h      = h_q;
        region.done   = done_q;
    end

endmodule

// File: rtl/itu656_out_select.sv
module itu656_out_select
    import itu656_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  sel_e             sel,
    input  logic             exit_vld,
    input  logic [SYM_W-1:0] exit_sym,
    input  region_t          exit_region,
    input  logic             exit_ctrl,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_data
);

    logic open_win;
    logic keep;
    logic fire;

    assign open_win = exit_region.synced && !exit_region.done;

    always_comb begin
        unique case (sel)
            SEL_ACTIVE: keep = open_win && !exit_ctrl && !exit_region.v && !exit_region.h;
            SEL_VBLANK: keep = open_win && !exit_ctrl && exit_region.v;
            SEL_ALL:    keep = open_win;
            default:    keep = 1'b0;
        endcase
    end

    assign fire = push && exit_vld && keep;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_data <= exit_sym;
            end
        end
    end

endmodule

// File: rtl/itu656_filter.sv
module itu656_filter
    import itu656_pkg::*;
#(
    parameter int SYM_W  = 10,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_valid,
    input  logic [SYM_W-1:0]  sym_in,
    input  logic [1:0]        mode,
    input  logic [LINE_W-1:0] active_lines,
    output logic              out_valid,
    output logic [SYM_W-1:0]  out_data,
    output logic              synced,
    output logic              capture_done
);

    logic [WIN_LEN-1:0][SYM_W-1:0] win_sym;
    logic [WIN_LEN-1:0]            win_vld;
    logic                          hit;
    logic                          push_hit;
    trs_flags_t                    flags;
    region_t                       region;
    logic                          exit_vld;
    logic [SYM_W-1:0]              exit_sym;
    region_t                       exit_region;
    logic                          exit_ctrl;
    sel_e                          sel;

    assign sel      = sel_e'(mode);
    assign push_hit = sym_valid && hit;

    itu656_trs_detect #(.SYM_W(SYM_W)) u_detect (
        .win_sym (win_sym),
        .win_vld (win_vld),
        .cur_sym (sym_in),
        .hit     (hit),
        .flags   (flags)
    );

    itu656_timing_track #(.LINE_W(LINE_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .push       (sym_valid),
        .hit        (hit),
        .flags      (flags),
        .line_limit (active_lines),
        .region     (region)
    );

    itu656_sym_window #(.SYM_W(SYM_W)) u_window (
        .clk         (clk),
        .rst         (rst),
        .push        (sym_valid),
        .sym_in      (sym_in),
        .region_in   (region),
        .mark_ctrl   (push_hit),
        .win_sym     (win_sym),
        .win_vld     (win_vld),
        .exit_vld    (exit_vld),
        .exit_sym    (exit_sym),
        .exit_region (exit_region),
        .exit_ctrl   (exit_ctrl)
    );

    itu656_out_select #(.SYM_W(SYM_W)) u_select (
        .clk         (clk),
        .rst         (rst),
        .push        (sym_valid),
        .sel         (sel),
        .exit_vld    (exit_vld),
        .exit_sym    (exit_sym),
        .exit_region (exit_region),
        .exit_ctrl   (exit_ctrl),
        .out_valid   (out_valid),
        .out_data    (out_data)
    );

    assign synced       = region.synced;
    assign capture_done = region.done;

endmodule

// File: rtl/itu656_filter_chk.sv
module itu656_filter_chk #(
    parameter int SYM_W  = 10,
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              sym_valid,
    input logic [SYM_W-1:0]  sym_in,
    input logic [1:0]        mode,
    input logic [LINE_W-1:0] active_lines,
    input logic              out_valid,
    input logic [SYM_W-1:0]  out_data,
    input logic              synced,
    input logic              capture_done
);

    a_r3_sync_sticky: assert property (@(posedge clk) disable iff (rst)
        synced |=> synced);

    a_r3_no_out_unsynced: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> synced);

    a_r3_sync_needs_symbol: assert property (@(posedge clk) disable iff (rst)
        $rose(synced) |-> $past(sym_valid));

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
        capture_done |=> capture_done);

    a_r9_done_after_sync: assert property (@(posedge clk) disable iff (rst)
        capture_done |-> synced);

    a_r9_done_needs_limit: assert property (@(posedge clk) disable iff (rst)
        capture_done |-> (active_lines != '0));

    a_r10_idle_no_out: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> !out_valid);

    a_r8_none_silent: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |=> !out_valid);

endmodule

bind itu656_filter itu656_filter_chk #(.SYM_W(SYM_W), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/sim_itu656_filter.sv
module sim_itu656_filter;

    localparam int SW = 10;
    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sym_valid = 1'b0;
    logic [SW-1:0] sym_in = '0;
    logic [1:0]    mode = 2'd0;
    logic [LW-1:0] active_lines = '0;
    logic          out_valid;
    logic [SW-1:0] out_data;
    logic          synced;
    logic          capture_done;

    always #2.5 clk = ~clk;

    itu656_filter #(.SYM_W(SW), .LINE_W(LW)) u0 (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_in(sym_in),
        .mode(mode), .active_lines(active_lines), .out_valid(out_valid),
        .out_data(out_data), .synced(synced), .capture_done(capture_done)
    );

    int    total = 0;
    int    bad = 0;
    string tag = "R1";
    bit    cmp_en = 1'b0;
    int    put_n = 0;
    int    data_ctr = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    typedef struct {
        logic [9:0] s;
        bit c, sy, v, h, d;
    } ent_t;
    ent_t q[$];
    bit m_f, m_v, m_h, m_seen, m_sync, m_done;
    int m_cnt;
    bit exp_v;
    logic [9:0] exp_d;

    function automatic logic [7:0] mk_stat(bit f, bit v, bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic bit keep_of(ent_t e, logic [1:0] md);
        bit open_w;
        open_w = e.sy && !e.d;
        case (md)
            2'd0: return open_w && !e.c && !e.v && !e.h;
            2'd1: return open_w && !e.c && e.v;
            2'd2: return open_w;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        ent_t e;
        int n;
        logic [7:0] st;
        bit was;
        if (rst) begin
            q.delete();
            m_f = 0; m_v = 1; m_h = 1; m_seen = 0; m_sync = 0; m_done = 0; m_cnt = 0;
            exp_v = 0;
        end else begin
            exp_v = 0;
            if (sym_valid) begin
                e.s = sym_in; e.c = 0; e.sy = m_sync; e.v = m_v; e.h = m_h; e.d = m_done;
                q.push_back(e);
                n = q.size();
                st = sym_in[9:2];
                if (n >= 4 && q[n-4].s[9:2] == 8'hFF && q[n-3].s[9:2] == 8'h00 &&
                    q[n-2].s[9:2] == 8'h00 && st == mk_stat(st[6], st[5], st[4])) begin
                    for (int k = n - 4; k < n; k++) q[k].c = 1;
                    was = m_sync;
                    if (!m_sync && m_seen && m_f && !st[6]) m_sync = 1;
                    if (was && !m_done && st[4] && !st[5]) begin
                        m_cnt++;
                        if (active_lines != 0 && m_cnt == int'(active_lines)) m_done = 1;
                    end
                    m_f = st[6]; m_v = st[5]; m_h = st[4]; m_seen = 1;
                end
                if (n >= 4 && keep_of(q[n-4], mode)) begin
                    exp_v = 1;
                    exp_d = q[n-4].s;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(out_valid === exp_v, $sformatf("R4 R10 %s", tag), "out_valid", out_valid, exp_v);
            if (exp_v)
                chk(out_data === exp_d, $sformatf("R4 R11 %s", tag), "out_data", out_data, exp_d);
            chk(synced === m_sync, "R3", "synced", synced, m_sync);
            chk(capture_done === m_done, "R9", "capture_done", capture_done, m_done);
        end
    end

    // Stimulus
    task automatic put(logic [9:0] s);
        if (put_n % 5 == 4) begin
            @(negedge clk);
            sym_valid = 1'b0;
        end
        @(negedge clk);
        sym_valid = 1'b1;
        sym_in = s;
        put_n++;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            sym_valid = 1'b0;
        end
    endtask

    // Preamble low bits are nonzero on purpose (R11).
    task automatic trs_raw(logic [7:0] st);
        put({8'hFF, 2'b10});
        put({8'h00, 2'b01});
        put({8'h00, 2'b11});
        put({st, 2'b00});
    endtask

    task automatic line(bit f, bit v, int nact);
        trs_raw(mk_stat(f, v, 1'b1));
        for (int i = 0; i < 4; i++) put((i % 2) ? 10'h040 : 10'h200);
        trs_raw(mk_stat(f, v, 1'b0));
        for (int i = 0; i < nact; i++) begin
            put(10'h100 + 10'(data_ctr % 512));
            data_ctr++;
        end
    endtask

    task automatic frame();
        line(1, 1, 3);
        line(1, 0, 3);
        trs_raw(mk_stat(0, 1, 1) ^ 8'h01);   // bad protection bits
        idle(3);
        chk(synced === 1'b0, "R2", "synced after bad status", synced, 0);
        line(0, 1, 4);
        idle(2);
        chk(synced === 1'b1, "R3", "synced after field-1 start", synced, 1);
        line(0, 1, 3);
        line(0, 0, 5);
        trs_raw(mk_stat(0, 0, 1) ^ 8'h02);   // bad status inside active data (R2)
        put(10'h155);
        line(0, 0, 5);
        line(0, 0, 5);
        line(0, 0, 5);
        line(0, 1, 3);
        line(1, 1, 3);
        line(1, 0, 4);
        line(1, 0, 4);
        line(0, 1, 2);
        idle(4);
    endtask

    task automatic run(logic [1:0] md, int lim, string tg);
        @(negedge clk);
        cmp_en = 1'b0;
        rst = 1'b1;
        sym_valid = 1'b0;
        mode = md;
        active_lines = LW'(lim);
        @(negedge clk);
        chk(out_valid === 1'b0 && synced === 1'b0 && capture_done === 1'b0, "R1",
            "outputs in reset", {out_valid, synced, capture_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0 && synced === 1'b0 && capture_done === 1'b0, "R1",
            "outputs after reset", {out_valid, synced, capture_done}, 0);
        tag = tg;
        cmp_en = 1'b1;
        frame();
        chk(capture_done === (lim != 0), "R9", "final capture_done", capture_done, lim != 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        run(2'd0, 0, "R5");
        run(2'd1, 0, "R6");
        run(2'd2, 0, "R7");
        run(2'd3, 0, "R8");
        run(2'd0, 3, "R9 R5");
        run(2'd2, 2, "R9 R7");
        cmp_en = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule